// File: doc/BRIEF.md
# Row scan mapper with scroll

This block runs through the physical row-driver positions of a dot-matrix panel, one position for each line strobe. For each position it tells the memory fetch logic which display-memory row belongs there, or that the position is idle. The multiplex rate can be set to 65, 49 or 33 lines. A vertical mirror bit reverses the order of the display lines. A wrap-around scroll offset rotates the picture line by line without moving the icon line. The icon line comes from a fixed memory row, and the driver position that shows it depends on the rate, the mirror bit and an icon-placement bit.

The scan position is held in a small state machine. Its state gives the class of the current position: `SLOT_OFF` (idle), `SLOT_DISP` (display line) or `SLOT_ICON` (icon line). After reset the machine is in `SLOT_OFF`. On every clock it moves to the class of the next position, so on a line strobe it takes the class of the following position, and otherwise it takes the class of the current position under the current settings. From any state it can go to any of the three states. The block also produces a drive polarity with N-line inversion, and that polarity flips at every frame boundary.

Top module: `row_scan_mapper`

## Requirements
- R1: While reset is asserted, `drv_slot` is 0 and `fetch_en`, `icon_row` and `line_pol` are 0.
- R2: Each clock with `line_tick` high advances `drv_slot` by one. After position 64 it returns to 0, and that return ends a frame.
- R3: `mux_sel` encoding: 0 selects 65 lines, 1 selects 49 lines, and 2 or 3 select 33 lines. The number of display lines D is 64, 48 or 32 for these settings. With the mirror bit low, display positions are 0..D-1. For display position s, `fetch_en`=1, `icon_row`=0 and `mem_row` = (s + offset) mod D.
- R4: With `y_mirror` high, the display line index l is reversed to D-1-l before the offset is added.
- R5: With `y_mirror` low, the icon line is at driver position 64, 56 or 48 for 65, 49 or 33 lines. There the outputs are `icon_row`=1, `fetch_en`=1 and `mem_row`=64.
- R6: With `y_mirror` high and `icon_mode` low, the icon line is at position 0 for every rate. The display lines then occupy positions 1..D, with l = s-1.
- R7: With `y_mirror` high and `icon_mode` high, the icon line is at the same position as in R5.
- R8: Every position that is neither a display line nor the icon line is idle, with `fetch_en`=0, `icon_row`=0 and `mem_row`=0.
- R9: A `scroll_req` pulse with `scroll_dir`=0 adds one to the offset modulo D. With `scroll_dir`=1 it subtracts one modulo D. The icon line never moves.
- R10: A clock on which `mux_sel` differs from its value on the previous clock clears the offset to 0, and any scroll request on that clock is ignored.
- R11: Let k count the non-idle positions already scanned in the current frame, starting at 0. With N = `inv_lines` nonzero, `line_pol` = frame parity XOR bit 0 of floor(k/N). With N = 0, `line_pol` equals the frame parity. The frame parity is 0 for the first frame after reset and toggles at each frame end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | Advance to the next driver position |
| mux_sel | input | 2 | Multiplex rate select |
| y_mirror | input | 1 | Reverse display line order |
| icon_mode | input | 1 | Icon placement when mirrored |
| scroll_req | input | 1 | One-cycle scroll command |
| scroll_dir | input | 1 | 0 = add one, 1 = subtract one |
| inv_lines | input | 4 | Lines per polarity group, 0 = frame-only |
| drv_slot | output | 7 | Current driver position |
| fetch_en | output | 1 | Position needs a memory row |
| mem_row | output | 7 | Memory row to fetch |
| icon_row | output | 1 | Position carries the icon line |
| line_pol | output | 1 | Drive polarity |

## Verification
The hardest case to reach is the offset wrapping past either end of the display range while the mirror reverses the line order. Combined with an icon line that sits at the opposite end, this only shows up after long runs of scroll commands at one specific rate. The stimulus sweeps every rate and mirror/icon-placement combination. Between full frames it issues scroll runs that step the offset back below zero and forward past D. The frame after each rate change is checked for a cleared offset even though a scroll command arrived on the same clock.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
    typedef enum logic [1:0] {
        SLOT_OFF  = 2'd0,
        SLOT_DISP = 2'd1,
        SLOT_ICON = 2'd2
    } slot_cls_e;

    function automatic logic [1:0] rate_index(input logic [1:0] sel);
        return (sel == 2'd3) ? 2'd2 : sel;
    endfunction
endpackage

// File: rtl/rsm_scroll.sv
module rsm_scroll #(
    parameter int ROW_W = 7,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] mux_sel,
    input  logic             scroll_req,
    input  logic             scroll_dir,
    input  logic [ROW_W-1:0] disp_rows,
    output logic [ROW_W-1:0] offset
);
    logic [SEL_W-1:0] sel_q;
    logic             sel_change;

    assign sel_change = (mux_sel != sel_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset <= '0;
            sel_q  <= '0;
        end else begin
            sel_q <= mux_sel;
            if (sel_change) begin
                offset <= '0;
            end else if (scroll_req) begin
                if (!scroll_dir)
                    offset <= (offset >= disp_rows - 1'b1) ? '0 : offset + 1'b1;
                else
                    offset <= (offset == '0) ? disp_rows - 1'b1 : offset - 1'b1;
            end
        end
    end

    // R10
    mux_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_change |=> (offset == '0));

    // R9
    scroll_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_change && scroll_req && !scroll_dir && offset == disp_rows - 1'b1)
        |=> (offset == '0));
endmodule

// File: rtl/rsm_inv.sv
module rsm_inv #(
    parameter int INV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_tick,
    input  logic             frame_end,
    input  logic             slot_active,
    input  logic [INV_W-1:0] inv_lines,
    output logic             line_pol
);
    logic [INV_W-1:0] grp_cnt;
    logic             grp_par;
    logic             frame_par;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grp_cnt   <= '0;
            grp_par   <= 1'b0;
            frame_par <= 1'b0;
        end else if (line_tick) begin
            if (frame_end) begin
                grp_cnt   <= '0;
                grp_par   <= 1'b0;
                frame_par <= ~frame_par;
            end else if (slot_active && inv_lines != '0) begin
                if (grp_cnt >= inv_lines - 1'b1) begin
                    grp_cnt <= '0;
                    grp_par <= ~grp_par;
                end else begin
                    grp_cnt <= grp_cnt + 1'b1;
                end
            end
        end
    end

    assign line_pol = frame_par ^ grp_par;

    // R11
    pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(line_pol));

    // R11
    inv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && !frame_end && inv_lines == '0) |=> $stable(line_pol));
endmodule

// File: rtl/rsm_slot_fsm.sv
module rsm_slot_fsm
    import rsm_pkg::*;
#(
    parameter int DRV_LAST = 64,
    parameter int ROW_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_tick,
    input  logic [ROW_W-1:0] disp_rows,
    input  logic [ROW_W-1:0] icon_drv,
    input  logic             icon_first,
    output logic [ROW_W-1:0] slot,
    output logic             frame_end,
    output logic             disp_vld,
    output logic             icon_vld,
    output logic [ROW_W-1:0] line_idx
);
    slot_cls_e        state, state_d;
    logic [ROW_W-1:0] slot_d;

    assign frame_end = (slot == ROW_W'(DRV_LAST));
    assign slot_d    = !line_tick ? slot : (frame_end ? '0 : slot + 1'b1);

    always_comb begin
        if (icon_first) begin
            if (slot_d == '0)
                state_d = SLOT_ICON;
            else if (slot_d <= disp_rows)
                state_d = SLOT_DISP;
            else
                state_d = SLOT_OFF;
        end else begin
            if (slot_d == icon_drv)
                state_d = SLOT_ICON;
            else if (slot_d < disp_rows)
                state_d = SLOT_DISP;
            else
                state_d = SLOT_OFF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SLOT_OFF;
            slot  <= '0;
        end else begin
            state <= state_d;
            slot  <= slot_d;
        end
    end

    always_comb begin
        disp_vld = 1'b0;
        icon_vld = 1'b0;
        line_idx = '0;
        unique case (state)
            SLOT_OFF: begin
            end
            SLOT_DISP: begin
                disp_vld = 1'b1;
                line_idx = icon_first ? slot - 1'b1 : slot;
            end
            SLOT_ICON: begin
                icon_vld = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // R2
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && frame_end) |=> (slot == '0));

    // R2
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(slot));
endmodule

// File: rtl/row_scan_mapper.sv
module row_scan_mapper
    import rsm_pkg::*;
#(
    parameter int DRV_LAST  = 64,
    parameter int DISP_MAX  = 64,
    parameter int DISP_STEP = 16,
    parameter int ICON_STEP = 8,
    parameter int ROW_W     = 7,
    parameter int INV_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_tick,
    input  logic [1:0]       mux_sel,
    input  logic             y_mirror,
    input  logic             icon_mode,
    input  logic             scroll_req,
    input  logic             scroll_dir,
    input  logic [INV_W-1:0] inv_lines,
    output logic [ROW_W-1:0] drv_slot,
    output logic             fetch_en,
    output logic [ROW_W-1:0] mem_row,
    output logic             icon_row,
    output logic             line_pol
);
    localparam logic [ROW_W-1:0] ICON_MEM = ROW_W'(DISP_MAX);

    logic [1:0]       rate;
    logic [ROW_W-1:0] disp_rows;
    logic [ROW_W-1:0] icon_drv;
    logic             icon_first;
    logic [ROW_W-1:0] offset;
    logic             frame_end;
    logic             disp_vld;
    logic             icon_vld;
    logic [ROW_W-1:0] line_idx;
    logic [ROW_W-1:0] line_ord;
    logic [ROW_W:0]   row_sum;
    logic [ROW_W:0]   row_wrap;

    assign rate       = rate_index(mux_sel);
    assign disp_rows  = ROW_W'(DISP_MAX)  - ROW_W'(DISP_STEP * int'(rate));
    assign icon_drv   = ROW_W'(DRV_LAST)  - ROW_W'(ICON_STEP * int'(rate));
    assign icon_first = y_mirror & ~icon_mode;

    rsm_scroll #(.ROW_W(ROW_W), .SEL_W(2)) u_scroll (
        .clk        (clk),
        .rst_n      (rst_n),
        .mux_sel    (mux_sel),
        .scroll_req (scroll_req),
        .scroll_dir (scroll_dir),
        .disp_rows  (disp_rows),
        .offset     (offset)
    );

    rsm_slot_fsm #(.DRV_LAST(DRV_LAST), .ROW_W(ROW_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_tick  (line_tick),
        .disp_rows  (disp_rows),
        .icon_drv   (icon_drv),
        .icon_first (icon_first),
        .slot       (drv_slot),
        .frame_end  (frame_end),
        .disp_vld   (disp_vld),
        .icon_vld   (icon_vld),
        .line_idx   (line_idx)
    );

    rsm_inv #(.INV_W(INV_W)) u_inv (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_tick   (line_tick),
        .frame_end   (frame_end),
        .slot_active (disp_vld | icon_vld),
        .inv_lines   (inv_lines),
        .line_pol    (line_pol)
    );

    always_comb begin
        line_ord = y_mirror ? (disp_rows - 1'b1 - line_idx) : line_idx;
        row_sum  = {1'b0, line_ord} + {1'b0, offset};
        row_wrap = (row_sum >= {1'b0, disp_rows}) ? row_sum - {1'b0, disp_rows} : row_sum;
    end

    always_comb begin
        fetch_en = disp_vld | icon_vld;
        icon_row = icon_vld;
        if (icon_vld)
            mem_row = ICON_MEM;
        else if (disp_vld)
            mem_row = row_wrap[ROW_W-1:0];
        else
            mem_row = '0;
    end

    // R8
    no_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(disp_vld && icon_vld));

    // R8
    idle_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_en |-> (mem_row == '0 && !icon_row));
endmodule

// File: tb/sim_row_scan_mapper.sv
module sim_row_scan_mapper;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_tick = 1'b0;
    logic [1:0] mux_sel = 2'd0;
    logic       y_mirror = 1'b0;
    logic       icon_mode = 1'b0;
    logic       scroll_req = 1'b0;
    logic       scroll_dir = 1'b0;
    logic [3:0] inv_lines = 4'd0;
    logic [6:0] drv_slot;
    logic       fetch_en;
    logic [6:0] mem_row;
    logic       icon_row;
    logic       line_pol;

    int total = 0;
    int bad = 0;
    int bslot = 0, bframe = 0, bk = 0, boff = 0, bmux = 0;
    int cyc = 0;
    string ftag = "";

    always #(CLK_P/2) clk = ~clk;

    row_scan_mapper u0 (
        .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .mux_sel(mux_sel),
        .y_mirror(y_mirror), .icon_mode(icon_mode), .scroll_req(scroll_req),
        .scroll_dir(scroll_dir), .inv_lines(inv_lines), .drv_slot(drv_slot),
        .fetch_en(fetch_en), .mem_row(mem_row), .icon_row(icon_row),
        .line_pol(line_pol)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL R2 watchdog expired act=%0d exp=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int disp_of(input int m);
        return 64 - 16 * ((m == 3) ? 2 : m);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s slot=%0d act=%0d exp=%0d", tag, bslot, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // cls: 0 idle, 1 display, 2 icon
    task automatic model(input int s, output int cls, output int row);
        int d, idrv, l, lp;
        d = disp_of(int'(mux_sel));
        idrv = 64 - 8 * ((mux_sel == 2'd3) ? 2 : int'(mux_sel));
        cls = 0; row = 0; l = 0;
        if (y_mirror && !icon_mode) begin
            if (s == 0) cls = 2;
            else if (s <= d) begin cls = 1; l = s - 1; end
        end else begin
            if (s == idrv) cls = 2;
            else if (s < d) begin cls = 1; l = s; end
        end
        if (cls == 2) row = 64;
        if (cls == 1) begin
            lp = y_mirror ? d - 1 - l : l;
            row = (lp + boff) % d;
        end
    endtask

    task automatic tick(input int cls);
        line_tick = 1'b1;
        step();
        line_tick = 1'b0;
        if (bslot == 64) begin
            bslot = 0; bframe = bframe + 1; bk = 0;
        end else begin
            if (cls != 0) bk = bk + 1;
            bslot = bslot + 1;
        end
    endtask

    task automatic run_frame(input int n);
        int cls, row, ep;
        string tag;
        inv_lines = 4'(n);
        for (int s = 0; s < 65; s++) begin
            model(bslot, cls, row);
            chk("R2", int'(drv_slot), bslot);
            if (cls == 2)
                tag = (y_mirror && !icon_mode) ? "R6" : (y_mirror ? "R7" : "R5");
            else if (cls == 0)
                tag = "R8";
            else if (ftag != "")
                tag = ftag;
            else if (boff != 0)
                tag = "R9";
            else
                tag = y_mirror ? "R4" : "R3";
            chk(tag, {29'd0, fetch_en, icon_row, mem_row},
                {29'd0, (cls != 0) ? 1'b1 : 1'b0, (cls == 2) ? 1'b1 : 1'b0, 7'(row)});
            ep = (bframe & 1) ^ ((n != 0) ? ((bk / n) & 1) : 0);
            chk("R11", int'(line_pol), ep);
            tick(cls);
        end
        ftag = "";
    endtask

    task automatic scroll(input int dir, input int times);
        int d;
        d = disp_of(bmux);
        for (int i = 0; i < times; i++) begin
            scroll_req = 1'b1;
            scroll_dir = dir[0];
            step();
            scroll_req = 1'b0;
            boff = (dir == 0) ? (boff + 1) % d : (boff + d - 1) % d;
        end
    endtask

    task automatic set_cfg(input int m, input int mir, input int ic);
        mux_sel = 2'(m);
        y_mirror = mir[0];
        icon_mode = ic[0];
        scroll_req = 1'b1;
        scroll_dir = 1'b0;
        step();
        scroll_req = 1'b0;
        if (m != bmux) begin
            boff = 0;
            ftag = "R10";
        end else begin
            boff = (boff + 1) % disp_of(m);
        end
        bmux = m;
        step();
    endtask

    initial begin
        step();
        chk("R1", int'(drv_slot), 0);
        chk("R1", {30'd0, fetch_en, icon_row}, 0);
        chk("R1", int'(line_pol), 0);
        line_tick = 1'b1;
        step();
        line_tick = 1'b0;
        chk("R1", int'(drv_slot), 0);
        rst_n = 1'b1;
        step();
        step();
        for (int m = 0; m < 4; m++) begin
            for (int mir = 0; mir < 2; mir++) begin
                for (int ic = 0; ic < 2; ic++) begin
                    set_cfg(m, mir, ic);
                    run_frame(0);
                    scroll(0, 3);
                    run_frame(3);
                    scroll(1, 5);
                    run_frame(1);
                    scroll(0, disp_of(m) + 2);
                    run_frame(15);
                end
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule